// File: doc/BRIEF.md
# Keyboard/Mouse Controller Host Command Front End

This block is the part of a PS/2-style keyboard and mouse controller that the host processor sees. The host writes bytes through one port select line. Select 0 is the data port and select 1 is the command port. The host reads back a status byte and the contents of an output buffer. Inside the block, a sequencer takes in command bytes and the parameter bytes that follow them. It updates a configuration byte and an output port, or it places a byte into the output buffer on behalf of the first (keyboard) or second (auxiliary) device.

The sequencer consumes a byte only when a byte is waiting and the output buffer is empty. Every parameter byte waits on that same condition. A command issued while the host has not yet collected an earlier byte therefore stays parked and is not lost. It runs as soon as the host drains the buffer.

After each accepted byte the sequencer pauses for a fixed number of cycles. The output port carries the A20 gate line. Two of its bits show the interrupt request lines, and these follow the buffer state rather than anything written to them.

Top module: `kbc_host_if`

## Requirements
- R1: A waiting byte (status bit 1 set) is consumed only while status bit 0 (output buffer full) is clear. Otherwise it stays waiting for as long as the buffer stays full.
- R2: A host write to either port sets status bit 1. The bit clears when the sequencer consumes the byte.
- R3: Status bit 3 is 1 when the last host write went to the command port (select 1). It is 0 when the last write went to the data port (select 0).
- R4: After a byte is consumed, the next byte is consumed no sooner than LATENCY (default 12) cycles later. A byte written in the cycle the flag clears shows status bit 1 for exactly LATENCY samples.
- R5: Command 0xD2 followed by a data byte loads the output buffer with that byte and sets status bit 0, with status bit 5 clear. Command 0xD3 does the same with status bit 5 set.
- R6: Command 0x60 followed by a data byte loads the configuration byte. The first IRQ line is high exactly when the buffer is full, status bit 5 is clear and configuration bit 0 is set. The second IRQ line is high exactly when the buffer is full, status bit 5 is set and configuration bit 1 is set. Output port bits 4 and 5 show the first and second IRQ lines.
- R7: Command 0xD1 followed by a data byte loads output port bits 7:6 and 3:0 from that byte. The A20 gate follows bit 1. Bits 4 and 5 of the byte are ignored, and the status byte is unchanged.
- R8: A host read of the data port returns the buffered byte. It clears status bits 0 and 5, which lowers whichever IRQ line was high.
- R9: A 0xD1 command written while the output buffer is full is held intact. After the host reads the buffer, the command and its parameter take effect on the A20 gate.
- R10: An unknown command code is consumed and has no effect. A data byte with no command waiting for it is also consumed and has no effect.
- R11: After reset the status byte is 0x00, the output port is 0x02 (A20 high), both IRQ lines are low and the configuration byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostSel | input | 1 | Port select: 0 data, 1 command |
| hostWrData | input | 8 | Byte written by the host |
| hostRd | input | 1 | Host read strobe for the data port |
| hostRdData | output | 8 | Output buffer contents |
| status | output | 8 | Bit 0 buffer full, bit 1 byte waiting, bit 3 last write was command, bit 5 buffered byte from second device |
| outPort | output | 8 | Output port; bit 1 A20, bits 4/5 IRQ lines |
| a20Gate | output | 1 | A20 gate line |
| irqKbd | output | 1 | First device interrupt request |
| irqAux | output | 1 | Second device interrupt request |

## Verification
The sequencer is driven with command and parameter pairs for each of the four known codes. This shows that each code steers its parameter to the right register, and that each buffer-filling code gets its own source flag. The same buffer fills are then repeated with the interrupt enables cleared and then set, which separates the enable gating from the buffer state. A command written while the buffer is still full is left waiting for many cycles and then released by a host read. This separates a correct hold from a dropped or half-applied command. Unknown codes, stray data bytes and a parameter carrying the IRQ bit positions show that ignored input leaves every visible output untouched.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_WR_CFG   = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_WR_PORT  = 8'hD1;
  localparam logic [BYTE_W-1:0] CMD_WR_KBDOB = 8'hD2;
  localparam logic [BYTE_W-1:0] CMD_WR_AUXOB = 8'hD3;

  localparam logic [BYTE_W-1:0] PORT_RESET = 8'h02;
  localparam int PORT_A20_BIT  = 1;
  localparam int PORT_IRQK_BIT = 4;
  localparam int PORT_IRQA_BIT = 5;
  localparam int CFG_IRQK_EN   = 0;
  localparam int CFG_IRQA_EN   = 1;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_CFG, PEND_PORT, PEND_KBD, PEND_AUX
  } pend_t;

  typedef struct packed {
    logic accept;
    logic loadCfg;
    logic loadPort;
    logic loadKbdOb;
    logic loadAuxOb;
  } seqStrobes_t;
endpackage

// File: rtl/kbc_seq_ctrl.sv
module kbc_seq_ctrl
  import kbc_pkg::*;
#(
  parameter int LATENCY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ibf,
  input  logic              obf,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inIsCmd,
  output seqStrobes_t       strb
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);

  pend_t           pend;
  logic [CNT_W-1:0] busyCnt;
  logic            gate;

  assign gate = ibf && !obf && (busyCnt == '0);

  always_comb begin
    strb = '0;
    strb.accept = gate;
    if (gate && !inIsCmd) begin
      case (pend)
        PEND_CFG:  strb.loadCfg   = 1'b1;
        PEND_PORT: strb.loadPort  = 1'b1;
        PEND_KBD:  strb.loadKbdOb = 1'b1;
        PEND_AUX:  strb.loadAuxOb = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= PEND_NONE;
      busyCnt <= '0;
    end else begin
      if (gate) begin
        busyCnt <= CNT_LOAD;
        if (inIsCmd) begin
          case (inByte)
            CMD_WR_CFG:   pend <= PEND_CFG;
            CMD_WR_PORT:  pend <= PEND_PORT;
            CMD_WR_KBDOB: pend <= PEND_KBD;
            CMD_WR_AUXOB: pend <= PEND_AUX;
            default:      pend <= PEND_NONE;
          endcase
        end else begin
          pend <= PEND_NONE;
        end
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  // Checker: cycles since the last accept, saturating
  logic [CNT_W:0] sinceAccept;
  always_ff @(posedge clk) begin
    if (!rstN) sinceAccept <= (CNT_W + 1)'(LATENCY);
    else if (strb.accept) sinceAccept <= '0;
    else if (sinceAccept < (CNT_W + 1)'(LATENCY)) sinceAccept <= sinceAccept + 1'b1;
  end

  AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |-> sinceAccept >= (CNT_W + 1)'(LATENCY)); // R4
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadCfg, strb.loadPort, strb.loadKbdOb, strb.loadAuxOb})); // R5
endmodule

// File: rtl/kbc_datapath.sv
module kbc_datapath
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostSel,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              hostRd,
  input  seqStrobes_t       strb,
  output logic              ibf,
  output logic              obf,
  output logic [BYTE_W-1:0] inByte,
  output logic              inIsCmd,
  output logic [BYTE_W-1:0] hostRdData,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] outPort,
  output logic              a20Gate,
  output logic              irqKbd,
  output logic              irqAux
);
  logic              auxSrc;
  logic [BYTE_W-1:0] obData;
  logic [BYTE_W-1:0] cfgByte;
  logic [BYTE_W-1:0] portLatch;
  logic              obLoad;

  assign obLoad = strb.loadKbdOb || strb.loadAuxOb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibf       <= 1'b0;
      inByte    <= '0;
      inIsCmd   <= 1'b0;
      obf       <= 1'b0;
      auxSrc    <= 1'b0;
      obData    <= '0;
      cfgByte   <= '0;
      portLatch <= PORT_RESET;
    end else begin
      if (hostWr) begin
        ibf     <= 1'b1;
        inByte  <= hostWrData;
        inIsCmd <= hostSel;
      end else if (strb.accept) begin
        ibf <= 1'b0;
      end
      if (obLoad) begin
        obf    <= 1'b1;
        auxSrc <= strb.loadAuxOb;
        obData <= inByte;
      end else if (hostRd) begin
        obf    <= 1'b0;
        auxSrc <= 1'b0;
      end
      if (strb.loadCfg)  cfgByte   <= inByte;
      if (strb.loadPort) portLatch <= inByte;
    end
  end

  assign irqKbd     = obf && !auxSrc && cfgByte[CFG_IRQK_EN];
  assign irqAux     = obf && auxSrc && cfgByte[CFG_IRQA_EN];
  assign hostRdData = obData;
  assign a20Gate    = portLatch[PORT_A20_BIT];
  assign status     = {2'b00, auxSrc, 1'b0, inIsCmd, 1'b0, ibf, obf};

  always_comb begin
    outPort = portLatch;
    outPort[PORT_IRQK_BIT] = irqKbd;
    outPort[PORT_IRQA_BIT] = irqAux;
  end

  AST_IBF_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ibf && !strb.accept |=> ibf); // R1
  AST_OB_NOT_CLOBBERED: assert property (@(posedge clk) disable iff (!rstN)
    obLoad |-> !obf); // R1
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept && !hostWr |=> !ibf); // R2
  AST_IRQ_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rstN)
    (irqKbd || irqAux) |-> obf); // R6
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqKbd, irqAux})); // R6
  AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && !obLoad |=> !obf && !status[5]); // R8
  AST_PORT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPort |=> $stable(portLatch)); // R7
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int LATENCY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostSel,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              hostRd,
  output logic [BYTE_W-1:0] hostRdData,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] outPort,
  output logic              a20Gate,
  output logic              irqKbd,
  output logic              irqAux
);
  seqStrobes_t       strb;
  logic              ibf, obf, inIsCmd;
  logic [BYTE_W-1:0] inByte;

  kbc_seq_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .ibf(ibf), .obf(obf),
    .inByte(inByte), .inIsCmd(inIsCmd), .strb(strb)
  );

  kbc_datapath u_dp (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRd(hostRd), .strb(strb),
    .ibf(ibf), .obf(obf), .inByte(inByte), .inIsCmd(inIsCmd),
    .hostRdData(hostRdData), .status(status), .outPort(outPort),
    .a20Gate(a20Gate), .irqKbd(irqKbd), .irqAux(irqAux)
  );
endmodule

// File: tb/kbc_host_if_test.sv
module kbc_host_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0, hostSel = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData, status, outPort;
  logic a20Gate, irqKbd, irqAux;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_host_if #(.LATENCY(LATENCY)) uut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRd(hostRd), .hostRdData(hostRdData),
    .status(status), .outPort(outPort), .a20Gate(a20Gate),
    .irqKbd(irqKbd), .irqAux(irqAux)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic hostWrite(bit sel, logic [7:0] d);
    hostWr = 1'b1; hostSel = sel; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(output logic [7:0] d);
    hostRd = 1'b1;
    d = hostRdData;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic waitIbfClear();
    for (int i = 0; i < 200 && status[1]; i++) @(negedge clk);
  endtask

  task automatic sendCmd(logic [7:0] c, logic [7:0] p);
    hostWrite(1'b1, c); waitIbfClear();
    hostWrite(1'b0, p); waitIbfClear();
  endtask

  task automatic testReset();
    check("R11 status", status, 8'h00);
    check("R11 outPort", outPort, 8'h02);
    check("R11 a20", a20Gate, 1);
    check("R11 irqs", {irqKbd, irqAux}, 0);
  endtask

  task automatic testLatency();
    int n = 0;
    hostWrite(1'b1, 8'h60);
    check("R2 ibf set", status[1], 1);
    check("R3 cmd flag", status[3], 1);
    waitIbfClear();
    check("R2 ibf cleared", status[1], 0);
    hostWrite(1'b0, 8'h03);
    check("R3 data flag", status[3], 0);
    while (status[1] && n < 100) begin n++; @(negedge clk); end
    check("R4 busy samples", n, LATENCY);
  endtask

  task automatic testBuffers();
    logic [7:0] d;
    sendCmd(8'hD2, 8'hA5);
    check("R5 kbd status", status, 8'h01);
    check("R6 kbd irq", {irqKbd, irqAux}, 2'b10);
    check("R6 outPort kbd", outPort, 8'h12);
    hostRead(d);
    check("R8 read data", d, 8'hA5);
    check("R8 status after read", status, 8'h00);
    check("R8 irq low", {irqKbd, irqAux}, 0);
    sendCmd(8'hD3, 8'h5A);
    check("R5 aux status", status, 8'h21);
    check("R6 aux irq", {irqKbd, irqAux}, 2'b01);
    check("R6 outPort aux", outPort, 8'h22);
    hostRead(d);
    check("R8 read aux", d, 8'h5A);
    check("R8 aux cleared", status, 8'h00);
    sendCmd(8'h60, 8'h00);
    sendCmd(8'hD2, 8'h33);
    check("R6 disabled irq", {irqKbd, irqAux}, 0);
    check("R6 disabled status", status, 8'h01);
    hostRead(d);
  endtask

  task automatic testPort();
    sendCmd(8'hD1, 8'hF1);
    check("R7 port value", outPort, 8'hC1);
    check("R7 a20 low", a20Gate, 0);
    check("R7 status untouched", status, 8'h00);
    sendCmd(8'hD1, 8'h02);
    check("R7 a20 high", a20Gate, 1);
  endtask

  task automatic testHeld();
    logic [7:0] d;
    sendCmd(8'hD2, 8'h11);
    hostWrite(1'b1, 8'hD1);
    repeat (40) @(negedge clk);
    check("R1 held status", status, 8'h0B);
    check("R9 a20 before drain", a20Gate, 1);
    hostRead(d);
    check("R9 drained data", d, 8'h11);
    waitIbfClear();
    check("R1 consumed after drain", status[1], 0);
    hostWrite(1'b0, 8'h00);
    waitIbfClear();
    check("R9 a20 after drain", a20Gate, 0);
    sendCmd(8'hD1, 8'h02);
  endtask

  task automatic testIgnored();
    hostWrite(1'b1, 8'hAA); waitIbfClear();
    hostWrite(1'b0, 8'h77); waitIbfClear();
    check("R10 status", status, 8'h00);
    check("R10 outPort", outPort, 8'h02);
    hostWrite(1'b0, 8'hD2); waitIbfClear();
    check("R10 stray data", status, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatency();
    testBuffers();
    testPort();
    testHeld();
    testIgnored();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule